// File: doc/BRIEF.md
# GPIO Pin-Mode Multiplexer Bank

This block sits between a set of device pads and the peripherals that share them. It groups the pins into ports of different widths. Each pin is steered by a two-bit mode code. The code makes the pin one of four things: a plain input that is not driven, a pin owned by its peripheral, a GPIO output held low, or a GPIO output held high. The code's high bit comes from the port's "mode-high" register and its low bit from the port's "mode-low" register, both at the pin's own bit position. The high bit works as the GPIO output enable. When that bit is set, the low bit is the driven level.

Software reaches the block through a flat register window. Every port takes four word slots: mode-low, mode-high, a synchronized pin-level readback, and a reserved slot. Reads are combinational. A write lands on the clock edge that samples it, and the pad follows straight away. After reset every pin belongs to its peripheral. In that mode the pad data and pad enable come through without a register stage. Every peripheral always sees the raw pad level, whatever the pin's mode.

Top module: `pinmux_bank`

## Requirements
- R1: Pin b of port p (flat pad index = sum of the widths of ports 0..p-1, plus b) is controlled by bit b of port p's mode-high register (code bit 1) and bit b of its mode-low register (code bit 0).
- R2: With code 00 the pad is released: pad_oe is 0 and pad_do is 0.
- R3: With code 01, pad_do equals per_do and pad_oe equals per_oe for that pin, combinationally in the same cycle.
- R4: With code 10 the pad is driven low (pad_oe=1, pad_do=0). With code 11 it is driven high (pad_oe=1, pad_do=1).
- R5: After reset every implemented mode-low bit reads 1 and every mode-high bit reads 0, so every pad follows its peripheral.
- R6: Register bits at or above a port's width read as 0, and writes to them have no effect.
- R7: A write with reg_wr=1 changes the addressed register at the rising edge that samples it, and the pads reflect the change right after that edge, not before it. No other register changes.
- R8: The pin-level register of port p returns pad_di for that port's pins, delayed by two rising edges through a synchronizer, in every mode. Writes to it are ignored.
- R9: per_di equals pad_di for every pin in every mode.
- R10: reg_addr = 4*p + s, where s=0 is mode-low, s=1 is mode-high, s=2 is pin level and s=3 is reserved. Reserved slots and addresses with p >= the number of ports read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register window |
| reg_addr | input | ADDR_W (4) | Word address, 4*port + slot |
| reg_wdata | input | DATA_W (8) | Write data |
| reg_rdata | output | DATA_W (8) | Combinational read data |
| per_do | input | TOTAL_PINS (11) | Peripheral output data per pin |
| per_oe | input | TOTAL_PINS (11) | Peripheral output enable per pin |
| per_di | output | TOTAL_PINS (11) | Pad level returned to the peripherals |
| pad_do | output | TOTAL_PINS (11) | Pad output data |
| pad_oe | output | TOTAL_PINS (11) | Pad output enable |
| pad_di | input | TOTAL_PINS (11) | Pad input level |

## Verification
On every cycle the assertions check that each pad's enable and data agree with the registered mode bits (the released, pass-through and driven codes). They also check that a mode register takes the written value one edge after a write and otherwise holds still, that the level readback matches the pad two edges earlier, and that upper and unmapped read bits stay zero. Only the bench scenarios can show the reset values, which flat pad bit each port bit reaches, that a write to one port leaves the other ports untouched, and the exact edge at which a pad changes. The bench also checks that writes to the readback and reserved slots leave every register as it was.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

   // two-bit per-pin mode code: {mode-high bit, mode-low bit}
   typedef enum logic [1:0] {
      PM_RELEASE  = 2'b00,
      PM_PERIPH   = 2'b01,
      PM_DRIVE_LO = 2'b10,
      PM_DRIVE_HI = 2'b11
   } pin_mode_e;

   // word slot inside one port's four-word window
   typedef enum logic [1:0] {
      SLOT_MLO   = 2'd0,
      SLOT_MHI   = 2'd1,
      SLOT_LEVEL = 2'd2,
      SLOT_RSVD  = 2'd3
   } reg_slot_e;

   localparam int unsigned SLOTS_PER_PORT = 4;

endpackage

// File: rtl/pinmux_sync.sv
module pinmux_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pinmux_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("pinmux_sync: W must be at least 1");
   end

   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/pinmux_cell.sv
module pinmux_cell
   import pinmux_pkg::*;
(
   input  logic mhi,
   input  logic mlo,
   input  logic per_do,
   input  logic per_oe,
   output logic pad_do,
   output logic pad_oe
);

   pin_mode_e mode;
   assign mode = pin_mode_e'({mhi, mlo});

   always_comb begin
      unique case (mode)
         PM_RELEASE:  begin pad_oe = 1'b0;   pad_do = 1'b0;   end
         PM_PERIPH:   begin pad_oe = per_oe; pad_do = per_do; end
         PM_DRIVE_LO: begin pad_oe = 1'b1;   pad_do = 1'b0;   end
         PM_DRIVE_HI: begin pad_oe = 1'b1;   pad_do = 1'b1;   end
         default:     begin pad_oe = 1'b0;   pad_do = 1'b0;   end
      endcase
   end

endmodule

// File: rtl/pinmux_port.sv
module pinmux_port
   import pinmux_pkg::*;
#(
   parameter int unsigned W           = 4,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [DATA_W-1:0] wdata,
   input  logic [W-1:0]      per_do,
   input  logic [W-1:0]      per_oe,
   input  logic [W-1:0]      pad_di,
   output logic [W-1:0]      mlo_q,
   output logic [W-1:0]      mhi_q,
   output logic [W-1:0]      level_q,
   output logic [W-1:0]      pad_do,
   output logic [W-1:0]      pad_oe
);

   if (W < 1 || W > DATA_W) begin : g_bad_w
      $error("pinmux_port: W must be in 1..DATA_W");
   end

   // mode registers; reset leaves every pin with its peripheral
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mlo_q <= '1;
         mhi_q <= '0;
      end else begin
         if (wr_lo) mlo_q <= wdata[W-1:0];
         if (wr_hi) mhi_q <= wdata[W-1:0];
      end
   end

   pinmux_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_di),
      .q     (level_q)
   );

   for (genvar b = 0; b < W; b++) begin : g_pin
      pinmux_cell u_cell (
         .mhi    (mhi_q[b]),
         .mlo    (mlo_q[b]),
         .per_do (per_do[b]),
         .per_oe (per_oe[b]),
         .pad_do (pad_do[b]),
         .pad_oe (pad_oe[b])
      );

      p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (!mhi_q[b] && !mlo_q[b]) |-> (!pad_oe[b] && !pad_do[b]));
      p_periph_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (!mhi_q[b] && mlo_q[b]) |-> (pad_oe[b] == per_oe[b] && pad_do[b] == per_do[b]));
      p_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
         mhi_q[b] |-> (pad_oe[b] && pad_do[b] == mlo_q[b]));
   end

   p_hi_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi |=> mhi_q == $past(wdata[W-1:0]));
   p_lo_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> mlo_q == $past(wdata[W-1:0]));
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_hi && !wr_lo) |=> ($stable(mhi_q) && $stable(mlo_q)));

   // cycles since reset release, saturating, bounds the readback check window
   logic [1:0] age_q;
   always_ff @(posedge clk) begin
      if (!rst_n)              age_q <= '0;
      else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
   end

   if (SYNC_STAGES == 2) begin : g_level_chk
      p_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (age_q >= 2'd2) |-> level_q == $past(pad_di, 2));
   end

endmodule

// File: rtl/pinmux_bank.sv
module pinmux_bank
   import pinmux_pkg::*;
#(
   parameter int unsigned NUM_PORTS           = 3,
   parameter int unsigned DATA_W              = 8,
   parameter int unsigned PORT_W [NUM_PORTS]  = '{6, 4, 1},
   parameter int unsigned TOTAL_PINS          = 11,
   parameter int unsigned SYNC_STAGES         = 2,
   localparam int unsigned ADDR_W = $clog2(NUM_PORTS * SLOTS_PER_PORT)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic [DATA_W-1:0]     reg_wdata,
   output logic [DATA_W-1:0]     reg_rdata,
   input  logic [TOTAL_PINS-1:0] per_do,
   input  logic [TOTAL_PINS-1:0] per_oe,
   output logic [TOTAL_PINS-1:0] per_di,
   output logic [TOTAL_PINS-1:0] pad_do,
   output logic [TOTAL_PINS-1:0] pad_oe,
   input  logic [TOTAL_PINS-1:0] pad_di
);

   localparam int unsigned IDX_W = ADDR_W - 2;

   function automatic int unsigned pin_base(int unsigned p);
      int unsigned s = 0;
      for (int unsigned i = 0; i < p; i++) s += PORT_W[i];
      return s;
   endfunction

   localparam int unsigned SUM_W = pin_base(NUM_PORTS);

   if (NUM_PORTS < 2) begin : g_bad_ports
      $error("pinmux_bank: NUM_PORTS must be at least 2");
   end
   if (SUM_W != TOTAL_PINS) begin : g_bad_total
      $error("pinmux_bank: TOTAL_PINS must equal the sum of PORT_W");
   end

   reg_slot_e        slot;
   logic [IDX_W-1:0] port_idx;
   assign slot     = reg_slot_e'(reg_addr[1:0]);
   assign port_idx = reg_addr[ADDR_W-1:2];

   logic [NUM_PORTS*DATA_W-1:0] rd_flat;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      localparam int unsigned W = PORT_W[p];
      localparam int unsigned B = pin_base(p);

      logic            hit;
      logic [W-1:0]    mlo, mhi, lvl;
      logic [DATA_W-1:0] rd_word;

      assign hit = (port_idx == IDX_W'(p));

      pinmux_port #(.W(W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_port (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_lo   (reg_wr && hit && slot == SLOT_MLO),
         .wr_hi   (reg_wr && hit && slot == SLOT_MHI),
         .wdata   (reg_wdata),
         .per_do  (per_do[B +: W]),
         .per_oe  (per_oe[B +: W]),
         .pad_di  (pad_di[B +: W]),
         .mlo_q   (mlo),
         .mhi_q   (mhi),
         .level_q (lvl),
         .pad_do  (pad_do[B +: W]),
         .pad_oe  (pad_oe[B +: W])
      );

      always_comb begin
         rd_word = '0;
         unique case (slot)
            SLOT_MLO:   rd_word[W-1:0] = mlo;
            SLOT_MHI:   rd_word[W-1:0] = mhi;
            SLOT_LEVEL: rd_word[W-1:0] = lvl;
            default:    rd_word = '0;
         endcase
      end

      assign rd_flat[p*DATA_W +: DATA_W] = rd_word;

      if (W < DATA_W) begin : g_upper_chk
         p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            hit |-> reg_rdata[DATA_W-1:W] == '0);
      end
   end

   always_comb begin
      reg_rdata = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (port_idx == IDX_W'(p)) reg_rdata = rd_flat[p*DATA_W +: DATA_W];
      end
   end

   assign per_di = pad_di;

   p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (slot == SLOT_RSVD || int'(port_idx) >= int'(NUM_PORTS)) |-> reg_rdata == '0);

endmodule

// File: tb/sim_pinmux_bank.sv
module sim_pinmux_bank;

   localparam int NP    = 3;
   localparam int DW    = 8;
   localparam int TOT   = 11;
   localparam int AW    = 4;
   localparam int PW [NP]   = '{6, 4, 1};
   localparam int BASE [NP] = '{0, 6, 10};

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           reg_wr = 1'b0;
   logic [AW-1:0]  reg_addr = '0;
   logic [DW-1:0]  reg_wdata = '0;
   logic [DW-1:0]  reg_rdata;
   logic [TOT-1:0] per_do = '0, per_oe = '0, per_di, pad_do, pad_oe, pad_di = '0;

   // bench model of the mode bits, flat pad order (R1)
   logic [TOT-1:0] m_hi, m_lo;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;  // 125 MHz

   pinmux_bank u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .per_do(per_do),
      .per_oe(per_oe), .per_di(per_di), .pad_do(pad_do), .pad_oe(pad_oe),
      .pad_di(pad_di)
   );

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // expected pads from the mode codes (R2, R3, R4)
   task automatic check_pads(input string req);
      logic [TOT-1:0] edo, eoe;
      for (int i = 0; i < TOT; i++) begin
         case ({m_hi[i], m_lo[i]})
            2'b00: begin eoe[i] = 1'b0;      edo[i] = 1'b0;      end
            2'b01: begin eoe[i] = per_oe[i]; edo[i] = per_do[i]; end
            2'b10: begin eoe[i] = 1'b1;      edo[i] = 1'b0;      end
            default: begin eoe[i] = 1'b1;    edo[i] = 1'b1;      end
         endcase
      end
      check(req, "pad_oe", 32'(pad_oe), 32'(eoe));
      check(req, "pad_do", 32'(pad_do), 32'(edo));
   endtask

   task automatic wr(input int addr, input logic [DW-1:0] data);
      int p = addr / 4;
      int s = addr % 4;
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = AW'(addr); reg_wdata = data;
      @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b0;
      if (p < NP) begin
         for (int b = 0; b < PW[p]; b++) begin
            if (s == 0) m_lo[BASE[p]+b] = data[b];
            if (s == 1) m_hi[BASE[p]+b] = data[b];
         end
      end
   endtask

   task automatic rd(input int addr, output logic [DW-1:0] data);
      @(negedge clk);
      reg_addr = AW'(addr);
      #1 data = reg_rdata;
   endtask

   task automatic check_all_regs(input string req);
      logic [DW-1:0] d;
      for (int p = 0; p < NP; p++) begin
         logic [DW-1:0] elo = '0, ehi = '0;
         for (int b = 0; b < PW[p]; b++) begin
            elo[b] = m_lo[BASE[p]+b];
            ehi[b] = m_hi[BASE[p]+b];
         end
         rd(4*p + 0, d); check(req, $sformatf("port%0d mode-low", p), 32'(d), 32'(elo));
         rd(4*p + 1, d); check(req, $sformatf("port%0d mode-high", p), 32'(d), 32'(ehi));
      end
   endtask

   task automatic t_reset();
      m_lo = '1; m_hi = '0;
      per_do = 11'h2A5; per_oe = 11'h0F0;
      check_all_regs("R5");
      #1 check_pads("R5");
      check("R3", "pad_do follows per_do", 32'(pad_do), 32'(11'h2A5));
      per_do = 11'h35A; per_oe = 11'h70F;
      #1 check("R3", "pad_oe follows per_oe same cycle", 32'(pad_oe), 32'(11'h70F));
   endtask

   task automatic t_drive_and_latency();
      // write mode-high of port 0, check pad before and after the edge (R7)
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 4'd1; reg_wdata = 8'h3F;
      #1 check("R7", "pad_oe before write edge", 32'(pad_oe[5:0]), 32'(per_oe[5:0]));
      @(posedge clk);
      #1 check("R7", "pad_oe after write edge", 32'(pad_oe[5:0]), 32'h3F);
      @(negedge clk);
      reg_wr = 1'b0;
      m_hi[5:0] = 6'h3F;
      wr(0, 8'h15);
      check_pads("R4");
      check("R4", "port0 driven levels", 32'(pad_do[5:0]), 32'h15);
      check("R7", "port1 untouched", 32'(pad_do[9:6]), 32'(per_do[9:6]));
      check_all_regs("R7");
   endtask

   task automatic t_release();
      wr(1, 8'h00);
      wr(0, 8'h00);
      check("R2", "port0 released oe", 32'(pad_oe[5:0]), 32'h0);
      check("R2", "port0 released do", 32'(pad_do[5:0]), 32'h0);
      check_pads("R2");
   endtask

   task automatic t_mixed_codes();
      // port1 pins: 0->00, 1->01, 2->10, 3->11 (R1 bit positions)
      wr(5, 8'b1100);
      wr(4, 8'b1010);
      per_do = 11'h7FF; per_oe = 11'h7FF;
      #1 check_pads("R1");
      check("R1", "port1 pad_oe", 32'(pad_oe[9:6]), 32'b1110);
      check("R1", "port1 pad_do", 32'(pad_do[9:6]), 32'b1010);
      wr(9, 8'h01); wr(8, 8'h01);
      check("R4", "port2 drive high", 32'({pad_oe[10], pad_do[10]}), 32'b11);
      wr(8, 8'h00);
      check("R4", "port2 drive low", 32'({pad_oe[10], pad_do[10]}), 32'b10);
   endtask

   task automatic t_unused_bits();
      logic [DW-1:0] d;
      wr(8, 8'hFF);
      rd(8, d); check("R6", "port2 mode-low upper bits", 32'(d), 32'h01);
      wr(5, 8'hF5);
      rd(5, d); check("R6", "port1 mode-high upper bits", 32'(d), 32'h05);
      check_pads("R6");
   endtask

   task automatic t_unmapped();
      logic [DW-1:0] d;
      wr(3, 8'hAA);
      wr(12, 8'h55);
      wr(15, 8'h33);
      rd(3, d);  check("R10", "reserved slot reads 0", 32'(d), 32'h0);
      rd(13, d); check("R10", "unmapped port reads 0", 32'(d), 32'h0);
      check_all_regs("R10");
   endtask

   task automatic t_level();
      logic [DW-1:0] d;
      @(negedge clk);
      pad_di = 11'h5A3;
      #1 check("R9", "per_di follows pad_di", 32'(per_di), 32'(11'h5A3));
      @(posedge clk);
      @(negedge clk);
      reg_addr = 4'd2;
      #1 check("R8", "level after one edge still old", 32'(reg_rdata), 32'h0);
      rd(2, d);  check("R8", "port0 level", 32'(d), 32'h23);
      rd(6, d);  check("R8", "port1 level", 32'(d), 32'h6);
      rd(10, d); check("R8", "port2 level", 32'(d), 32'h1);
      wr(2, 8'h00);
      rd(2, d);  check("R8", "level write ignored", 32'(d), 32'h23);
      check_all_regs("R8");
      pad_di = 11'h0;
      #1 check("R9", "per_di low", 32'(per_di), 32'h0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_drive_and_latency();
      t_release();
      t_mixed_codes();
      t_unused_bits();
      t_unmapped();
      t_level();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule